// File: doc/BRIEF.md
# Multimode Register with Mode-Dependent Status

An eight-bit register (width set by a parameter) whose update on each rising clock edge is chosen by a three-bit mode code. The modes are two add modes, two count modes, a serial shift, a parallel load from either of two ports, and hold. A single multipurpose input acts as carry-in, count enable or serial data, depending on the mode. A single status output reports adder carry-out, all-ones terminal count, the serial bit leaving the register, or the parity of the register, again depending on the mode.

Each of the two data ports is split into an input bus, an output bus and an active-low output enable. A port that is enabled presents the register contents on its output bus and raises its drive flag. The system around the block resolves each physical bus: when a port is enabled, its input bus carries the register's own value. An asynchronous active-low reset clears the register and silences the status output at once. Its release is synchronised to the clock.

Top module: `multimode_reg`

## Requirements
- R1: While `rst_n` is low, the register is zero and `status` is low at once, with no clock edge needed. After `rst_n` rises, the register ignores the first two rising edges and `status` stays low until the second of them. The third rising edge is the first to apply a mode.
- R2: Mode code 0 (add with carry) loads the register with `a_in + q + mpx_in`, modulo 2^W.
- R3: Mode code 1 (plain add) loads `a_in + q`, modulo 2^W. `mpx_in` has no effect on the result, and `b_in` never feeds the adder in either add mode.
- R4: In mode codes 0 and 1, `status` is the carry out of that same sum. It is combinational, so it is valid before the edge that captures the sum.
- R5: Mode code 2 increments the register when `mpx_in` is 1 and holds it when `mpx_in` is 0. Mode code 3 increments regardless of `mpx_in`. The all-ones value wraps to zero.
- R6: In mode codes 2 and 3, `status` is 1 exactly when every register bit is 1. This holds whether or not the count is enabled.
- R7: Mode code 4 shifts left: `mpx_in` enters bit 0, each bit n moves to bit n+1, and `status` shows the current top bit.
- R8: Mode code 5 loads `a_in` and mode code 6 loads `b_in`. `mpx_in` is ignored in both.
- R9: Mode code 7 holds the register unchanged, whatever `mpx_in`, `a_in` and `b_in` do.
- R10: In mode codes 5, 6 and 7, `status` is 1 when the register holds an odd number of ones and 0 when the count is even.
- R11: `a_drv` equals the inverse of `a_oe_n`. `a_out` equals the register when `a_oe_n` is 0 and is zero otherwise. Port B behaves the same way with `b_drv`, `b_oe_n` and `b_out`. The enables never change the register's own operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 3 | Mode code 0..7 |
| mpx_in | input | 1 | Carry-in, count enable or serial data, by mode |
| a_in | input | W | Port A input bus |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_out | output | W | Register value when port A is enabled, else zero |
| a_drv | output | 1 | High while port A drives |
| b_in | input | W | Port B input bus |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_out | output | W | Register value when port B is enabled, else zero |
| b_drv | output | 1 | High while port B drives |
| status | output | 1 | Carry-out, terminal count, serial out or parity, by mode |

## Verification
The bench builds the block with its default width of 8 and two reset-release stages. At this width every register value is reachable within a few hundred random steps, so the all-ones terminal count, the carry out of a full eight-bit sum and the wrap from 255 to 0 all occur in practice. The two-stage release makes the idle edges after reset a fixed, short window that the bench models exactly. Each port's input bus is resolved to the register value whenever that port is enabled, which exercises the self-reload in both load modes.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  typedef enum logic [2:0] {
    MD_ADD_CI = 3'd0,
    MD_ADD    = 3'd1,
    MD_CNT_EN = 3'd2,
    MD_CNT    = 3'd3,
    MD_SHIFT  = 3'd4,
    MD_LD_A   = 3'd5,
    MD_LD_B   = 3'd6,
    MD_HOLD   = 3'd7
  } mmr_mode_e;

  typedef enum logic [1:0] {
    SK_CARRY  = 2'd0,
    SK_SERIAL = 2'd1,
    SK_PARITY = 2'd2
  } mmr_stat_e;

  // Which status source each mode presents.
  function automatic mmr_stat_e stat_kind(mmr_mode_e m);
    mmr_stat_e k;
    case (m)
      MD_ADD_CI, MD_ADD, MD_CNT_EN, MD_CNT: k = SK_CARRY;
      MD_SHIFT:                             k = SK_SERIAL;
      default:                              k = SK_PARITY;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/mmr_rst_sync.sv
module mmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mmr_ripple_add.sv
module mmr_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]  = op_a[i] ^ op_b[i] ^ c[i];
      assign c[i+1]  = (op_a[i] & op_b[i]) | (c[i] & (op_a[i] ^ op_b[i]));
    end
  endgenerate

  assign cout = c[W];
endmodule

// File: rtl/mmr_next.sv
module mmr_next
  import mmr_pkg::*;
#(
  parameter int W = 8
) (
  input  mmr_mode_e    md,
  input  logic         mpx,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] q,
  output logic [W-1:0] q_nxt,
  output logic         q_en,
  output logic         carry
);
  logic [W-1:0] op_b;
  logic         op_c;
  logic [W-1:0] add_sum;

  // Operand steering: counting reuses the adder as q + 0 + 1.
  always_comb begin
    op_b = a_in;
    op_c = 1'b0;
    case (md)
      MD_ADD_CI:         op_c = mpx;
      MD_CNT_EN, MD_CNT: begin
        op_b = '0;
        op_c = 1'b1;
      end
      default: ;
    endcase
  end

  mmr_ripple_add #(.W(W)) u_add (
    .op_a (q),
    .op_b (op_b),
    .cin  (op_c),
    .sum  (add_sum),
    .cout (carry)
  );

  // Result selection and clock enable.
  always_comb begin
    q_nxt = q;
    q_en  = 1'b0;
    case (md)
      MD_ADD_CI, MD_ADD, MD_CNT: begin
        q_nxt = add_sum;
        q_en  = 1'b1;
      end
      MD_CNT_EN: begin
        q_nxt = add_sum;
        q_en  = mpx;
      end
      MD_SHIFT: begin
        q_nxt = {q[W-2:0], mpx};
        q_en  = 1'b1;
      end
      MD_LD_A: begin
        q_nxt = a_in;
        q_en  = 1'b1;
      end
      MD_LD_B: begin
        q_nxt = b_in;
        q_en  = 1'b1;
      end
      default: begin
        q_nxt = q;
        q_en  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mmr_status.sv
module mmr_status
  import mmr_pkg::*;
#(
  parameter int W = 8
) (
  input  mmr_mode_e    md,
  input  logic         live,
  input  logic         carry,
  input  logic [W-1:0] q,
  output logic         status
);
  mmr_stat_e kind;
  logic      raw;

  always_comb begin
    kind = stat_kind(md);
    case (kind)
      SK_CARRY:  raw = carry;
      SK_SERIAL: raw = q[W-1];
      default:   raw = ^q;
    endcase
    status = live & raw;
  end
endmodule

// File: rtl/multimode_reg.sv
module multimode_reg
  import mmr_pkg::*;
#(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic         mpx_in,
  input  logic [W-1:0] a_in,
  input  logic         a_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic         status
);
  mmr_mode_e    md;
  logic         rst_sync_n;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;
  logic         carry;

  assign md = mmr_mode_e'(mode);

  mmr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mmr_next #(.W(W)) u_next (
    .md    (md),
    .mpx   (mpx_in),
    .a_in  (a_in),
    .b_in  (b_in),
    .q     (q_r),
    .q_nxt (q_nxt),
    .q_en  (q_en),
    .carry (carry)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  q_r <= '0;
    else if (q_en)    q_r <= q_nxt;
  end

  mmr_status #(.W(W)) u_stat (
    .md     (md),
    .live   (rst_sync_n),
    .carry  (carry),
    .q      (q_r),
    .status (status)
  );

  assign a_drv = ~a_oe_n;
  assign b_drv = ~b_oe_n;
  assign a_out = a_oe_n ? '0 : q_r;
  assign b_out = b_oe_n ? '0 : q_r;
endmodule

// File: rtl/multimode_reg_chk.sv
module multimode_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [2:0]   mode,
  input logic         mpx_in,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] q,
  input logic         status
);
  always @(negedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_clear_R1: assert (q == '0 && status == 1'b0);
    end
  end

  assert_add_plain_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == 3'd1 |=> q == W'($past(a_in) + $past(q)));

  assert_count_gated_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd2 && !mpx_in) |=> $stable(q));

  assert_count_free_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == 3'd3 |=> q == W'($past(q) + 1'b1));

  assert_term_count_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd2 || mode == 3'd3) |-> status == (&q));

  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == 3'd4 |=> q == {$past(q[W-2:0]), $past(mpx_in)});

  assert_load_b_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == 3'd6 |=> q == $past(b_in));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == 3'd7 |=> $stable(q));

  assert_parity_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd5 || mode == 3'd6 || mode == 3'd7) |-> status == (^q));
endmodule

bind multimode_reg multimode_reg_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mode       (mode),
  .mpx_in     (mpx_in),
  .a_in       (a_in),
  .b_in       (b_in),
  .q          (q_r),
  .status     (status)
);

// File: tb/sim_multimode_reg.sv
module sim_multimode_reg;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode;
  logic         mpx;
  logic [W-1:0] a_src, b_src;
  logic         a_oe_n, b_oe_n;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_out, b_out;
  logic         a_drv, b_drv, status;

  int           n_chk  = 0;
  int           n_fail = 0;
  logic [W-1:0] exp_q;
  int           sync_left;
  string        q_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus resolution: an enabled port carries the register's own value.
  assign a_bus = a_oe_n ? a_src : a_out;
  assign b_bus = b_oe_n ? b_src : b_out;

  multimode_reg #(.W(W), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mpx_in(mpx),
    .a_in(a_bus), .a_oe_n(a_oe_n), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_bus), .b_oe_n(b_oe_n), .b_out(b_out), .b_drv(b_drv),
    .status(status)
  );

  function automatic logic [W-1:0] model_next(logic [2:0] m, logic [W-1:0] q,
                                              logic [W-1:0] a, logic [W-1:0] b, logic ci);
    case (m)
      3'd0: return W'(a + q + W'(ci));
      3'd1: return W'(a + q);
      3'd2: return ci ? W'(q + 1) : q;
      3'd3: return W'(q + 1);
      3'd4: return {q[W-2:0], ci};
      3'd5: return a;
      3'd6: return b;
      default: return q;
    endcase
  endfunction

  function automatic logic model_stat(logic [2:0] m, logic [W-1:0] q, logic [W-1:0] a, logic ci);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, q} + ((m == 3'd0) ? (W+1)'(ci) : '0);
    case (m)
      3'd0, 3'd1: return s[W];
      3'd2, 3'd3: return &q;
      3'd4:       return q[W-1];
      default:    return ^q;
    endcase
  endfunction

  function automatic string next_tag(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R5";
      3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string stat_tag(logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R4";
      3'd2, 3'd3: return "R6";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [2:0] m, logic ci, logic [W-1:0] av, logic [W-1:0] bv,
                      logic aoe, logic boe);
    logic [W-1:0] ae, be;
    @(negedge clk);
    mode = m; mpx = ci; a_src = av; b_src = bv; a_oe_n = aoe; b_oe_n = boe;
    #1;
    ae = aoe ? av : exp_q;
    be = boe ? bv : exp_q;
    if (!aoe) check(q_tag, "register on port A", a_out, exp_q);
    else      check("R11", "idle port A", a_out, '0);
    if (!boe) check(q_tag, "register on port B", b_out, exp_q);
    else      check("R11", "idle port B", b_out, '0);
    check("R11", "drive flags", W'({a_drv, b_drv}), W'({!aoe, !boe}));
    if (sync_left > 0)
      check("R1", "status during release", W'(status), '0);
    else
      check(stat_tag(m), "status", W'(status), W'(model_stat(m, exp_q, ae, ci)));
    @(posedge clk);
    if (sync_left > 0) begin
      sync_left--;
      q_tag = "R1";
    end else begin
      exp_q = model_next(m, exp_q, ae, be, ci);
      q_tag = next_tag(m);
    end
  endtask

  task automatic rand_steps(int n);
    for (int i = 0; i < n; i++) begin
      step(3'($urandom_range(7, 0)), 1'($urandom), W'($urandom), W'($urandom),
           1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; mode = 3'd0; mpx = 1'b1; a_src = '1; b_src = 8'h5A;
    a_oe_n = 1'b1; b_oe_n = 1'b0;
    exp_q = '0; sync_left = 2; q_tag = "R1";
    repeat (3) @(negedge clk);
    #1;
    // R1: add with carry would give carry 1 here; reset forces it low.
    check("R1", "status in reset", W'(status), '0);
    check("R1", "register in reset", b_out, '0);
    @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;

    // R1: two idle edges, then counting starts.
    step(3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);   // 0 -> 1
    // R8 load A all ones, then R2/R4 full carry: FF + 01 + 1 = 101
    step(3'd5, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b0);
    step(3'd0, 1'b1, 8'h01, 8'h00, 1'b1, 1'b0);
    // R3: carry-in ignored, B ignored: 01 + 10 = 11
    step(3'd1, 1'b1, 8'h10, 8'hEE, 1'b1, 1'b0);
    step(3'd1, 1'b0, 8'hF0, 8'h00, 1'b1, 1'b0);
    // R8 load B FE with port A enabled
    step(3'd6, 1'b1, 8'h00, 8'hFE, 1'b0, 1'b1);
    // R5/R6: gated count to FF, gated hold at FF (TC high), free count wraps
    step(3'd2, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd2, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd3, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    // R7: shift pattern in
    step(3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd4, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    // R8: load A with port A enabled reloads the register itself
    step(3'd5, 1'b1, 8'h3C, 8'h00, 1'b0, 1'b1);
    step(3'd5, 1'b0, 8'hC3, 8'h00, 1'b0, 1'b0);
    // R9/R10: hold while inputs move
    step(3'd7, 1'b1, 8'hAA, 8'h55, 1'b1, 1'b1);
    step(3'd7, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b0);
    step(3'd7, 1'b1, 8'h12, 8'h34, 1'b1, 1'b0);

    rand_steps(600);

    // R1: asynchronous reset in the middle of operation
    b_oe_n = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    check("R1", "async clear of register", b_out, '0);
    check("R1", "async clear of status", W'(status), '0);
    exp_q = '0; sync_left = 2; q_tag = "R1";
    #1 rst_n = 1'b1;
    step(3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    step(3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);

    rand_steps(300);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule